// File: doc/BRIEF.md
# Interrupt Status and Clear Unit

This block collects the twelve interrupt events of a two-wire bus controller. Each event goes into a raw status register. A mask register selects which raw bits may raise the single interrupt line. Ten of the sources are sticky: a one-cycle pulse sets the bit, and the bit stays set until software clears it. The receive-full and transmit-empty sources are level sources. They follow their input, which reflects a FIFO threshold, and no read clears them.

Software clears sticky bits by reading clear addresses. Each source has its own clear address, and one further address clears every source at once. A separate register collects the reasons for a transmit abort, and the cause bits build up until they are cleared. Reading the transmit-abort clear address, or the clear-all address, also empties this cause register. Software must therefore read the cause register before it clears the abort. A clear never drops an event that arrives in the same cycle as the clear.

Top module: `irq_status_clear`

## Requirements
- R1: The source bit order in every status register is: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on a sticky source input sets its raw bit at the next clock edge, and the bit then holds. The raw status reads at word address 0.
- R2: Bits 2 and 4 are level sources. Each raw bit equals its input one cycle earlier, and reads of clear addresses do not change it.
- R3: The mask register sits at address 1 and takes wr_data on a write. The masked status reads at address 2 and equals raw AND mask.
- R4: irq is high exactly when at least one masked status bit is set.
- R5: A read of address 16+i returns raw bit i in rdata bit 0. At the next edge it clears only sticky bit i.
- R6: A read of address 4 returns the raw status. At the next edge it clears every sticky bit and the abort-cause register.
- R7: An event that arrives in the same cycle as a read that would clear its bit leaves the bit set. The same holds for abort-cause bits.
- R8: The abort-cause register reads at address 3. It ORs in cause_in every cycle. Cause bits 0 to 5, 7 and 9 to 12 are implemented, and bits 6 and 8 always read 0.
- R9: A read of address 22, the tx abort clear, also clears the abort-cause register at the next edge.
- R10: After reset, the raw status and the abort causes are 0, irq is 0, and the mask is 0x254 (rx full, tx empty, tx abort, stop seen).
- R11: Writes to any address other than 1 change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 12 | Event pulses (sticky bits) and levels (bits 2 and 4) |
| cause_in | input | 13 | Transmit-abort cause pulses |
| rd_en | input | 1 | Register read strobe; clear addresses act on it |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Word address |
| wr_data | input | 12 | Write data (mask) |
| rd_data | output | 32 | Read data, valid in the cycle of rd_en |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a collision: an event on a bit in the very cycle that a clear read of that bit is sampled. The abort variant is harder still, where new cause bits arrive while the abort clear is read. Directed steps line up an event pulse and the matching clear read in one cycle, for a single source, for the clear-all address and for the abort cause. Random traffic then issues clear reads often, so that many more such collisions occur alongside irregular mask writes.

// File: rtl/irqsc_pkg.sv
package irqsc_pkg;
  localparam int unsigned SRC_N   = 12;
  localparam int unsigned CAUSE_N = 13;

  localparam int unsigned BIT_RX_FULL  = 2;
  localparam int unsigned BIT_TX_EMPTY = 4;
  localparam int unsigned BIT_TX_ABORT = 6;

  localparam logic [SRC_N-1:0]   LEVEL_SET  = 12'h014;
  localparam logic [SRC_N-1:0]   MASK_RESET = 12'h254;
  localparam logic [CAUSE_N-1:0] CAUSE_USED = 13'h1EBF;

  localparam int unsigned ADDR_RAW      = 0;
  localparam int unsigned ADDR_MASK     = 1;
  localparam int unsigned ADDR_MASKED   = 2;
  localparam int unsigned ADDR_CAUSE    = 3;
  localparam int unsigned ADDR_CLR_ALL  = 4;
  localparam int unsigned ADDR_CLR_BASE = 16;
endpackage

// File: rtl/irqsc_cell.sv
module irqsc_cell #(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic q
);
  logic d;

  generate
    if (IS_LEVEL) begin : g_level
      always_comb d = evt;
    end else begin : g_sticky
      always_comb d = evt | (q & ~clr);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/irqsc_cause.sv
module irqsc_cause #(
  parameter int unsigned W = 13,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cause_in,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         upd;

  always_comb begin
    upd = clr | (|(cause_in & USED));
    d   = (cause_in & USED) | (q & ~{W{clr}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end
endmodule

// File: rtl/irqsc_regif.sv
module irqsc_regif
  import irqsc_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned DW    = 32,
  parameter int unsigned NS    = SRC_N,
  parameter int unsigned NC    = CAUSE_N,
  parameter logic [NS-1:0] MRST = MASK_RESET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NS-1:0] wr_data,
  input  logic [NS-1:0] raw,
  input  logic [NC-1:0] cause,
  output logic [DW-1:0] rd_data,
  output logic [NS-1:0] mask,
  output logic [NS-1:0] clr_vec,
  output logic          clr_cause
);
  logic          mask_we;
  logic [NS-1:0] mask_d;
  logic          hit_all;

  always_comb begin
    mask_we = wr_en && (addr == AW'(ADDR_MASK));
    mask_d  = wr_data;
    hit_all = rd_en && (addr == AW'(ADDR_CLR_ALL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask <= MRST;
    else if (mask_we) mask <= mask_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_clr
      always_comb
        clr_vec[gi] = hit_all || (rd_en && (addr == AW'(ADDR_CLR_BASE + gi)));
    end
  endgenerate

  always_comb clr_cause = clr_vec[BIT_TX_ABORT];

  always_comb begin
    rd_data = '0;
    if (addr == AW'(ADDR_RAW))          rd_data = DW'(raw);
    else if (addr == AW'(ADDR_MASK))    rd_data = DW'(mask);
    else if (addr == AW'(ADDR_MASKED))  rd_data = DW'(raw & mask);
    else if (addr == AW'(ADDR_CAUSE))   rd_data = DW'(cause);
    else if (addr == AW'(ADDR_CLR_ALL)) rd_data = DW'(raw);
    else begin
      for (int i = 0; i < NS; i++)
        if (addr == AW'(ADDR_CLR_BASE + i)) rd_data = DW'(raw[i]);
    end
  end
endmodule

// File: rtl/irq_status_clear.sv
module irq_status_clear
  import irqsc_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32,
  parameter int unsigned NS = SRC_N,
  parameter int unsigned NC = CAUSE_N,
  parameter logic [NS-1:0] LEVELS = LEVEL_SET,
  parameter logic [NS-1:0] MRST   = MASK_RESET,
  parameter logic [NC-1:0] CUSED  = CAUSE_USED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_in,
  input  logic [NC-1:0] cause_in,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [NS-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  logic [NS-1:0] raw_q;
  logic [NS-1:0] mask_q;
  logic [NS-1:0] clr_vec;
  logic          clr_cause;
  logic [NC-1:0] cause_q;
  logic [NS-1:0] masked;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_src
      irqsc_cell #(.IS_LEVEL(LEVELS[gi])) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (src_in[gi]),
        .clr  (clr_vec[gi]),
        .q    (raw_q[gi])
      );
    end
  endgenerate

  irqsc_cause #(.W(NC), .USED(CUSED)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_in(cause_in),
    .clr     (clr_cause),
    .q       (cause_q)
  );

  irqsc_regif #(.AW(AW), .DW(DW), .NS(NS), .NC(NC), .MRST(MRST)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .raw      (raw_q),
    .cause    (cause_q),
    .rd_data  (rd_data),
    .mask     (mask_q),
    .clr_vec  (clr_vec),
    .clr_cause(clr_cause)
  );

  always_comb begin
    masked = raw_q & mask_q;
    irq    = |masked;
  end
endmodule

// File: rtl/irqsc_checker.sv
module irqsc_checker #(
  parameter int unsigned NS = 12,
  parameter int unsigned NC = 13,
  parameter logic [NS-1:0] LEVELS = '0,
  parameter logic [NC-1:0] CUSED  = '1,
  parameter int unsigned TX_ABORT_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NS-1:0] src_in,
  input logic [NC-1:0] cause_in,
  input logic [NS-1:0] raw,
  input logic [NS-1:0] mask,
  input logic [NS-1:0] clr_vec,
  input logic [NC-1:0] cause,
  input logic          irq
);
  logic started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((raw & LEVELS) == ($past(src_in) & LEVELS)));

  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((($past(src_in) & ~LEVELS) & ~raw) == '0));

  a_r1_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((($past(raw) & ~$past(clr_vec) & ~LEVELS) & ~raw) == '0));

  a_r1_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (((raw & ~LEVELS) & ~$past(raw) & ~$past(src_in)) == '0));

  a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw & mask)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cause & ~CUSED) == '0);

  a_r9_cause_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(clr_vec[TX_ABORT_BIT])) |-> ((cause & ~$past(cause_in)) == '0));
endmodule

bind irq_status_clear irqsc_checker #(
  .NS(NS), .NC(NC), .LEVELS(LEVELS), .CUSED(CUSED), .TX_ABORT_BIT(irqsc_pkg::BIT_TX_ABORT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .src_in  (src_in),
  .cause_in(cause_in),
  .raw     (raw_q),
  .mask    (mask_q),
  .clr_vec (clr_vec),
  .cause   (cause_q),
  .irq     (irq)
);

// File: tb/irq_status_clear_bench.sv
`timescale 1ns/1ps
module irq_status_clear_bench;
  logic        clk;
  logic        rst_n;
  logic [11:0] src_in;
  logic [12:0] cause_in;
  logic        rd_en, wr_en;
  logic [5:0]  addr;
  logic [11:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  logic [11:0] m_raw, m_mask;
  logic [12:0] m_cause;
  int checks = 0;
  int errors = 0;

  localparam logic [11:0] LEV  = 12'h014;
  localparam logic [12:0] USED = 13'h1EBF;

  irq_status_clear u_irq_status_clear (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cause_in(cause_in),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    if (a == 0) return {20'd0, m_raw};
    if (a == 1) return {20'd0, m_mask};
    if (a == 2) return {20'd0, m_raw & m_mask};
    if (a == 3) return {19'd0, m_cause};
    if (a == 4) return {20'd0, m_raw};
    if (a >= 16 && a < 28) return {31'd0, m_raw[a-16]};
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    if (a == 0) return "R1";
    if (a == 1 || a == 2) return "R3";
    if (a == 3) return "R8";
    if (a == 4) return "R6";
    if (a >= 16 && a < 28) return "R5";
    return "R11";
  endfunction

  task automatic step(input logic [11:0] s, input logic [12:0] c, input bit r,
                      input bit w, input logic [5:0] a, input logic [11:0] d,
                      input string req);
    logic [11:0] clr, nraw;
    logic [12:0] ncause;
    @(negedge clk);
    src_in = s; cause_in = c; rd_en = r; wr_en = w; addr = a; wr_data = d;
    #1;
    if (r) chk(req, rd_data, model_read(a));
    chk("R4", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
    clr = '0;
    for (int i = 0; i < 12; i++)
      clr[i] = r && (a == 6'(16 + i) || a == 6'd4);
    nraw   = (s & LEV) | (~LEV & (s | (m_raw & ~clr)));
    ncause = (c & USED) | (clr[6] ? 13'd0 : m_cause);
    @(posedge clk);
    m_raw = nraw;
    m_cause = ncause;
    if (w && a == 6'd1) m_mask = d;
  endtask

  task automatic idle();
    step(12'd0, 13'd0, 0, 0, 6'd0, 12'd0, "R4");
  endtask

  task automatic rd(input logic [5:0] a, input string req);
    step(12'd0, 13'd0, 1, 0, a, 12'd0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_in = '0; cause_in = '0; rd_en = 0; wr_en = 0; addr = '0; wr_data = '0;
    m_raw = '0; m_mask = 12'h254; m_cause = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset values
    rd(6'd0, "R10"); rd(6'd1, "R10"); rd(6'd3, "R10");

    // R1 sticky set and hold
    step(12'h001, 13'd0, 0, 0, 6'd0, 12'd0, "R1");
    idle(); rd(6'd0, "R1");
    // R2 level source follows input, survives clear
    step(12'h004, 13'd0, 0, 0, 6'd0, 12'd0, "R2");
    step(12'h004, 13'd0, 1, 0, 6'd18, 12'd0, "R2");
    rd(6'd0, "R2");
    rd(6'd0, "R2");
    // R5 single clear
    step(12'h00B, 13'd0, 0, 0, 6'd0, 12'd0, "R5");
    rd(6'd17, "R5"); rd(6'd0, "R5");
    // R7 event coinciding with its clear
    step(12'h001, 13'd0, 1, 0, 6'd16, 12'd0, "R7");
    rd(6'd0, "R7");
    // R8 cause accumulation and reserved bits
    step(12'd0, 13'h1FFF, 0, 0, 6'd0, 12'd0, "R8");
    rd(6'd3, "R8");
    rd(6'd22, "R9"); rd(6'd3, "R9");
    step(12'd0, 13'h0001, 0, 0, 6'd0, 12'd0, "R8");
    step(12'd0, 13'h0008, 0, 0, 6'd0, 12'd0, "R8");
    rd(6'd3, "R8");
    // R7 cause arriving with abort clear
    step(12'h040, 13'h1000, 1, 0, 6'd22, 12'd0, "R7");
    rd(6'd3, "R7"); rd(6'd0, "R7");
    // R6 clear all
    step(12'hFEB, 13'h0002, 0, 0, 6'd0, 12'd0, "R6");
    rd(6'd4, "R6"); rd(6'd0, "R6"); rd(6'd3, "R6");
    // R3 mask write and masked view; R11 ignored writes
    step(12'h0A1, 13'd0, 0, 1, 6'd1, 12'hFFF, "R3");
    rd(6'd2, "R3");
    step(12'd0, 13'd0, 0, 1, 6'd0, 12'h000, "R11");
    step(12'd0, 13'd0, 0, 1, 6'd2, 12'h000, "R11");
    rd(6'd0, "R11"); rd(6'd1, "R11"); rd(6'd40, "R11");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] s;
      logic [12:0] c;
      logic [5:0]  a;
      bit r, w;
      int k;
      s = 12'($urandom & $urandom & $urandom);
      c = ($urandom % 8 == 0) ? 13'($urandom) : 13'd0;
      r = ($urandom % 3 == 0);
      w = !r && ($urandom % 16 == 0);
      k = $urandom % 10;
      if (k < 5) a = 6'(k);
      else if (k < 9) a = 6'(16 + $urandom % 12);
      else a = 6'($urandom);
      step(s, c, r, w, a, 12'($urandom), tag_of(a));
    end

    report();
    $finish;
  end
endmodule